// File: doc/BRIEF.md
# Serial-Bus Core Control Register Bank

This block is the core control register bank of a node on a high-speed serial bus. It serves plain read and write requests that the transaction layer has already decoded. A request gives a byte offset into the register space, a byte length, up to `MAXQ` quadlets of write data and a read/write flag. One cycle later the block answers with a response code and up to `MAXQ` quadlets of read data.

The bank holds four kinds of state:
- the node-identity register, whose bus number can be written;
- the split-transaction timeout pair, which also drives a combined timeout count to the transaction timers;
- the cycle-time and bus-time pair, built on a live cycle counter input, with the seconds field carried forward in software-visible form when a sampled counter value is lower than the previous sample;
- the broadcast-channel register.

Lock-only arbitration registers, reset-start and the unimplemented busy-timeout slot are decoded here only so that they get the correct error code. A request that spans several quadlets walks consecutive registers in address order. It stops at the first quadlet that fails. Quadlets before that point still take effect.

Top module: `sbus_csr_bank`

## Requirements
- R1: A request returns a type error with no effect in any of these cases: its offset is not a multiple of four, its length is not a multiple of four, its length is zero, or it covers more than `MAXQ` quadlets. Response codes are 0 for complete, 1 for type error and 2 for address error.
- R2: `rsp_valid` pulses exactly one cycle after each accepted request. Response quadlet k sits in `rsp_rdata[32k+31:32k]`. Quadlets that were not read return zero.
- R3: Quadlet k of a request targets offset `req_offset + 4k`. The walk stops at the first quadlet that hits a hole, which gives an address error, or a type-error register. Earlier quadlets keep their effect and read data. The busy-timeout offset 0x210 and every offset outside the map below are holes.
- R4: The reset-start register at 0x00C returns a type error on read. A write to it completes and changes nothing.
- R5: The split-timeout high register at 0x018 stores only write bits 2:0. The low register at 0x01C stores only write bits 31:19. Both read back with all other bits zero.
- R6: `timeout_count` equals high × 8192 + (low register >> 19). After reset the low field is 800 and the high field is 0.
- R7: Every read that touches cycle time (0x200) or bus time (0x204) samples `cycle_count` once for the whole request. If the sample is lower than the previous sample, bus time increases by 128. Cycle-time reads return the sample.
- R8: A bus-time read returns the stored bits 31:7 ORed with `sample >> 25`. A bus-time write keeps write bits 31:7.
- R9: A write to cycle time becomes the previous sample used for the wrap comparison. The next cycle it also pulses `cycle_set` with the value on `cycle_set_data`.
- R10: The broadcast-channel register at 0x234 resets to 0x8000001F. Writes change only bit 30, which also drives `bcast_valid`.
- R11: The node-identity register at 0x008 reads as {bus number[9:0], `phys_id`[5:0], 16'h0}. The bus number resets to 0x3FF. A write loads it from write bits 31:22.
- R12: The lock-only offsets 0x21C, 0x220, 0x224 and 0x228 return a type error on both plain read and plain write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_offset | input | ADDR_W | Byte offset into the register space |
| req_len | input | LEN_W | Request length in bytes |
| req_wdata | input | MAXQ*32 | Write quadlets, slot k at bits 32k+31:32k |
| cycle_count | input | 32 | Live bus cycle counter |
| phys_id | input | 6 | Physical node number from the link |
| rsp_valid | output | 1 | Response present |
| rsp_code | output | 2 | 0 complete, 1 type error, 2 address error |
| rsp_rdata | output | MAXQ*32 | Read quadlets |
| timeout_count | output | 16 | Combined split-transaction timeout |
| node_bus | output | 10 | Current bus number |
| bcast_valid | output | 1 | Broadcast-channel valid bit |
| cycle_set | output | 1 | Pulse to reload the cycle counter |
| cycle_set_data | output | 32 | Reload value |

## Verification
The timing of each result is fixed by one register stage:
- The response code and read data for a request appear in the cycle after the request.
- `timeout_count`, `node_bus`, `bcast_valid` and `cycle_set` change on the same edge that registers the response.
- A write only becomes visible to a request issued after it.

The bench drives each request on a falling edge, drops `req_valid` on the next falling edge and samples every output right there. That point lies one rising edge later, in the middle of the response cycle. The wrap check depends on the order of requests, so the vector table is walked strictly in sequence, and the cycle-counter value is held until the next request.

// File: rtl/sbus_csr_pkg.sv
package sbus_csr_pkg;

  typedef enum logic [1:0] {
    RC_DONE = 2'd0,
    RC_TYPE = 2'd1,
    RC_ADDR = 2'd2
  } rcode_e;

  typedef enum logic [3:0] {
    K_HOLE,
    K_NODE,
    K_RSTART,
    K_SPLIT_HI,
    K_SPLIT_LO,
    K_CYCLE,
    K_BUSTIME,
    K_LOCKONLY,
    K_BCAST
  } kind_e;

  // quadlet indices (byte offset / 4); consecutive order matters for walks
  localparam int unsigned QI_NODE     = 32'h002;
  localparam int unsigned QI_RSTART   = 32'h003;
  localparam int unsigned QI_SPLIT_HI = 32'h006;
  localparam int unsigned QI_SPLIT_LO = 32'h007;
  localparam int unsigned QI_CYCLE    = 32'h080;
  localparam int unsigned QI_BUSTIME  = 32'h081;
  localparam int unsigned QI_LOCK0    = 32'h087;
  localparam int unsigned QI_LOCK1    = 32'h088;
  localparam int unsigned QI_LOCK2    = 32'h089;
  localparam int unsigned QI_LOCK3    = 32'h08A;
  localparam int unsigned QI_BCAST    = 32'h08D;

endpackage

// File: rtl/sbus_csr_decode.sv
module sbus_csr_decode
  import sbus_csr_pkg::*;
#(
  parameter int IDX_W = 11
) (
  input  logic [IDX_W-1:0] qidx,
  output kind_e            kind
);

  localparam logic [IDX_W-1:0] A_NODE   = IDX_W'(QI_NODE);
  localparam logic [IDX_W-1:0] A_RSTART = IDX_W'(QI_RSTART);
  localparam logic [IDX_W-1:0] A_SHI    = IDX_W'(QI_SPLIT_HI);
  localparam logic [IDX_W-1:0] A_SLO    = IDX_W'(QI_SPLIT_LO);
  localparam logic [IDX_W-1:0] A_CYC    = IDX_W'(QI_CYCLE);
  localparam logic [IDX_W-1:0] A_BUS    = IDX_W'(QI_BUSTIME);
  localparam logic [IDX_W-1:0] A_LK0    = IDX_W'(QI_LOCK0);
  localparam logic [IDX_W-1:0] A_LK1    = IDX_W'(QI_LOCK1);
  localparam logic [IDX_W-1:0] A_LK2    = IDX_W'(QI_LOCK2);
  localparam logic [IDX_W-1:0] A_LK3    = IDX_W'(QI_LOCK3);
  localparam logic [IDX_W-1:0] A_BC     = IDX_W'(QI_BCAST);

  always_comb begin
    kind = K_HOLE;
    case (qidx)
      A_NODE:                     kind = K_NODE;
      A_RSTART:                   kind = K_RSTART;
      A_SHI:                      kind = K_SPLIT_HI;
      A_SLO:                      kind = K_SPLIT_LO;
      A_CYC:                      kind = K_CYCLE;
      A_BUS:                      kind = K_BUSTIME;
      A_LK0, A_LK1, A_LK2, A_LK3: kind = K_LOCKONLY;
      A_BC:                       kind = K_BCAST;
      default:                    kind = K_HOLE;
    endcase
  end

endmodule

// File: rtl/sbus_csr_split.sv
module sbus_csr_split #(
  parameter int HI_BITS = 3,
  parameter int LO_BITS = 13,
  parameter int LO_RST  = 800,
  localparam int CNT_W  = HI_BITS + LO_BITS
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_hi,
  input  logic [HI_BITS-1:0] wd_hi,
  input  logic               wr_lo,
  input  logic [LO_BITS-1:0] wd_lo,
  output logic [HI_BITS-1:0] hi_q,
  output logic [LO_BITS-1:0] lo_q,
  output logic [CNT_W-1:0]   count_q
);

  logic [HI_BITS-1:0] hi_n;
  logic [LO_BITS-1:0] lo_n;

  always_comb begin
    hi_n = wr_hi ? wd_hi : hi_q;
    lo_n = wr_lo ? wd_lo : lo_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hi_q    <= '0;
      lo_q    <= LO_BITS'(LO_RST);
      count_q <= CNT_W'(LO_RST);
    end else begin
      hi_q    <= hi_n;
      lo_q    <= lo_n;
      count_q <= {hi_n, lo_n};
    end
  end

  // R5
  hi_keep_chk: assert property (@(posedge clk) disable iff (rst)
    !wr_hi |=> $stable(hi_q));

  // R5
  lo_keep_chk: assert property (@(posedge clk) disable iff (rst)
    !wr_lo |=> $stable(lo_q));

endmodule

// File: rtl/sbus_csr_timebase.sv
module sbus_csr_timebase #(
  parameter int CYC_W  = 32,
  parameter int FRAC_W = 7,
  localparam int HI_W  = CYC_W - FRAC_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rd_time,
  input  logic             wr_cycle,
  input  logic [CYC_W-1:0] wd_cycle,
  input  logic             wr_bus,
  input  logic [HI_W-1:0]  wd_bus,
  input  logic [CYC_W-1:0] cycle_count,
  output logic [CYC_W-1:0] cyc_sample,
  output logic [CYC_W-1:0] bus_read
);

  logic [CYC_W-1:0] last_q;
  logic [HI_W-1:0]  bus_hi_q;
  logic [HI_W-1:0]  bus_hi_n;
  logic             wrap;

  always_comb begin
    cyc_sample = cycle_count;
    wrap       = rd_time && (cycle_count < last_q);
    bus_hi_n   = bus_hi_q + HI_W'(wrap);
    bus_read   = {bus_hi_n, cycle_count[CYC_W-1 -: FRAC_W]};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      last_q   <= '0;
      bus_hi_q <= '0;
    end else begin
      if (wr_cycle)     last_q <= wd_cycle;
      else if (rd_time) last_q <= cycle_count;
      if (wr_bus)       bus_hi_q <= wd_bus;
      else              bus_hi_q <= bus_hi_n;
    end
  end

  // R7
  wrap_inc_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_time && !wr_bus && (cycle_count < last_q)) |=> (bus_hi_q == $past(bus_hi_q) + 1'b1));

  // R8
  bus_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!rd_time && !wr_bus) |=> $stable(bus_hi_q));

  // R9
  last_load_chk: assert property (@(posedge clk) disable iff (rst)
    wr_cycle |=> (last_q == $past(wd_cycle)));

endmodule

// File: rtl/sbus_csr_bank.sv
module sbus_csr_bank
  import sbus_csr_pkg::*;
#(
  parameter int          ADDR_W       = 12,
  parameter int          LEN_W        = 8,
  parameter int          MAXQ         = 4,
  parameter logic [9:0]  NODE_BUS_RST = 10'h3FF,
  localparam int         DW           = MAXQ * 32,
  localparam int         IDX_W        = ADDR_W - 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_offset,
  input  logic [LEN_W-1:0]  req_len,
  input  logic [DW-1:0]     req_wdata,
  input  logic [31:0]       cycle_count,
  input  logic [5:0]        phys_id,
  output logic              rsp_valid,
  output logic [1:0]        rsp_code,
  output logic [DW-1:0]     rsp_rdata,
  output logic [15:0]       timeout_count,
  output logic [9:0]        node_bus,
  output logic              bcast_valid,
  output logic              cycle_set,
  output logic [31:0]       cycle_set_data
);

  // ---------------- per-slot address decode ----------------
  logic [IDX_W-1:0] qidx [MAXQ];
  kind_e            kind [MAXQ];

  for (genvar k = 0; k < MAXQ; k++) begin : g_slot
    assign qidx[k] = {1'b0, req_offset[ADDR_W-1:2]} + IDX_W'(k);
    sbus_csr_decode #(.IDX_W(IDX_W)) u_dec (
      .qidx (qidx[k]),
      .kind (kind[k])
    );
  end

  // ---------------- walk and error priority ----------------
  logic [LEN_W-1:0] nq;
  logic             fmt_bad;
  logic             stop;
  logic [MAXQ-1:0]  act;
  rcode_e           code_n;

  always_comb begin
    nq      = req_len >> 2;
    fmt_bad = (req_offset[1:0] != 2'b00) || (req_len[1:0] != 2'b00) ||
              (nq == '0) || (nq > LEN_W'(MAXQ));
    stop    = fmt_bad;
    code_n  = fmt_bad ? RC_TYPE : RC_DONE;
    act     = '0;
    for (int k = 0; k < MAXQ; k++) begin
      if (!stop && (LEN_W'(k) < nq)) begin
        if (kind[k] == K_HOLE) begin
          stop   = 1'b1;
          code_n = RC_ADDR;
        end else if (kind[k] == K_LOCKONLY || (kind[k] == K_RSTART && !req_write)) begin
          stop   = 1'b1;
          code_n = RC_TYPE;
        end else begin
          act[k] = 1'b1;
        end
      end
    end
  end

  // ---------------- write steering ----------------
  logic        wr_node, wr_shi, wr_slo, wr_cyc, wr_bus, wr_bc, rd_time;
  logic [9:0]  wd_node;
  logic [2:0]  wd_shi;
  logic [12:0] wd_slo;
  logic [31:0] wd_cyc;
  logic [24:0] wd_bus;
  logic        wd_bc;

  always_comb begin
    wr_node = 1'b0; wr_shi = 1'b0; wr_slo = 1'b0;
    wr_cyc  = 1'b0; wr_bus = 1'b0; wr_bc  = 1'b0; rd_time = 1'b0;
    wd_node = '0; wd_shi = '0; wd_slo = '0; wd_cyc = '0; wd_bus = '0; wd_bc = 1'b0;
    for (int k = 0; k < MAXQ; k++) begin
      if (req_valid && act[k]) begin
        if (req_write) begin
          case (kind[k])
            K_NODE:     begin wr_node = 1'b1; wd_node = req_wdata[k*32+22 +: 10]; end
            K_SPLIT_HI: begin wr_shi  = 1'b1; wd_shi  = req_wdata[k*32 +: 3];     end
            K_SPLIT_LO: begin wr_slo  = 1'b1; wd_slo  = req_wdata[k*32+19 +: 13]; end
            K_CYCLE:    begin wr_cyc  = 1'b1; wd_cyc  = req_wdata[k*32 +: 32];    end
            K_BUSTIME:  begin wr_bus  = 1'b1; wd_bus  = req_wdata[k*32+7 +: 25];  end
            K_BCAST:    begin wr_bc   = 1'b1; wd_bc   = req_wdata[k*32+30];       end
            default:    ;
          endcase
        end else if (kind[k] == K_CYCLE || kind[k] == K_BUSTIME) begin
          rd_time = 1'b1;
        end
      end
    end
  end

  // ---------------- storage ----------------
  logic [2:0]  shi_q;
  logic [12:0] slo_q;
  logic [15:0] tcount_q;
  logic [31:0] cyc_sample, bus_read;
  logic [9:0]  node_bus_q;
  logic        bc_q;

  sbus_csr_split #(.HI_BITS(3), .LO_BITS(13), .LO_RST(800)) u_split (
    .clk     (clk),
    .rst     (rst),
    .wr_hi   (wr_shi),
    .wd_hi   (wd_shi),
    .wr_lo   (wr_slo),
    .wd_lo   (wd_slo),
    .hi_q    (shi_q),
    .lo_q    (slo_q),
    .count_q (tcount_q)
  );

  sbus_csr_timebase #(.CYC_W(32), .FRAC_W(7)) u_time (
    .clk         (clk),
    .rst         (rst),
    .rd_time     (rd_time),
    .wr_cycle    (wr_cyc),
    .wd_cycle    (wd_cyc),
    .wr_bus      (wr_bus),
    .wd_bus      (wd_bus),
    .cycle_count (cycle_count),
    .cyc_sample  (cyc_sample),
    .bus_read    (bus_read)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      node_bus_q <= NODE_BUS_RST;
      bc_q       <= 1'b0;
    end else begin
      if (wr_node) node_bus_q <= wd_node;
      if (wr_bc)   bc_q       <= wd_bc;
    end
  end

  // ---------------- read data ----------------
  logic [DW-1:0] rdata_n;

  always_comb begin
    rdata_n = '0;
    for (int k = 0; k < MAXQ; k++) begin
      if (act[k] && !req_write) begin
        case (kind[k])
          K_NODE:     rdata_n[k*32 +: 32] = {node_bus_q, phys_id, 16'h0000};
          K_SPLIT_HI: rdata_n[k*32 +: 32] = {29'd0, shi_q};
          K_SPLIT_LO: rdata_n[k*32 +: 32] = {slo_q, 19'd0};
          K_CYCLE:    rdata_n[k*32 +: 32] = cyc_sample;
          K_BUSTIME:  rdata_n[k*32 +: 32] = bus_read;
          K_BCAST:    rdata_n[k*32 +: 32] = {1'b1, bc_q, 25'd0, 5'h1F};
          default:    rdata_n[k*32 +: 32] = '0;
        endcase
      end
    end
  end

  // ---------------- registered response ----------------
  logic          rsp_valid_q, cyc_set_q;
  logic [1:0]    rsp_code_q;
  logic [DW-1:0] rsp_rdata_q;
  logic [31:0]   cyc_set_data_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid_q    <= 1'b0;
      rsp_code_q     <= RC_DONE;
      rsp_rdata_q    <= '0;
      cyc_set_q      <= 1'b0;
      cyc_set_data_q <= '0;
    end else begin
      rsp_valid_q <= req_valid;
      cyc_set_q   <= wr_cyc;
      if (wr_cyc) cyc_set_data_q <= wd_cyc;
      if (req_valid) begin
        rsp_code_q  <= code_n;
        rsp_rdata_q <= rdata_n;
      end
    end
  end

  assign rsp_valid      = rsp_valid_q;
  assign rsp_code       = rsp_code_q;
  assign rsp_rdata      = rsp_rdata_q;
  assign timeout_count  = tcount_q;
  assign node_bus       = node_bus_q;
  assign bcast_valid    = bc_q;
  assign cycle_set      = cyc_set_q;
  assign cycle_set_data = cyc_set_data_q;

  // R2
  rsp_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid);

  // R2
  rsp_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !rsp_valid);

  // R1
  misalign_type_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_offset[1:0] != 2'b00) |=> (rsp_code == RC_TYPE));

  // R10
  bcast_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !(req_valid && req_write) |=> $stable(bcast_valid));

  // R11
  node_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !(req_valid && req_write) |=> $stable(node_bus));

  // R9
  cycle_set_chk: assert property (@(posedge clk) disable iff (rst)
    cycle_set |-> $past(req_valid && req_write));

endmodule

// File: tb/test_sbus_csr_bank.sv
`timescale 1ns/1ps
module test_sbus_csr_bank;

  localparam int MAXQ = 4;
  localparam int DW   = MAXQ * 32;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          req_valid = 1'b0;
  logic          req_write = 1'b0;
  logic [11:0]   req_offset = '0;
  logic [7:0]    req_len = '0;
  logic [DW-1:0] req_wdata = '0;
  logic [31:0]   cycle_count = '0;
  logic [5:0]    phys_id = 6'h05;
  logic          rsp_valid;
  logic [1:0]    rsp_code;
  logic [DW-1:0] rsp_rdata;
  logic [15:0]   timeout_count;
  logic [9:0]    node_bus;
  logic          bcast_valid;
  logic          cycle_set;
  logic [31:0]   cycle_set_data;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  sbus_csr_bank #(.ADDR_W(12), .LEN_W(8), .MAXQ(MAXQ)) i_sbus_csr_bank (
    .clk, .rst, .req_valid, .req_write, .req_offset, .req_len, .req_wdata,
    .cycle_count, .phys_id, .rsp_valid, .rsp_code, .rsp_rdata,
    .timeout_count, .node_bus, .bcast_valid, .cycle_set, .cycle_set_data
  );

  typedef struct packed {
    logic          w;
    logic [11:0]   off;
    logic [7:0]    len;
    logic [127:0]  wd;
    logic [31:0]   cyc;
    logic [1:0]    code;
    logic [127:0]  rd;
    logic [7:0]    req;
  } vec_t;

  localparam int NV = 32;
  localparam vec_t VECS [NV] = '{
    // R11 node read, write, read back
    '{1'b0, 12'h008, 8'd4,  128'h0, 32'h0, 2'd0, 128'h0000_0000_0000_0000_0000_0000_FFC5_0000, 8'd11},
    '{1'b1, 12'h008, 8'd4,  128'h0000_0000_0000_0000_0000_0000_1234_5678, 32'h0, 2'd0, 128'h0, 8'd11},
    '{1'b0, 12'h008, 8'd4,  128'h0, 32'h0, 2'd0, 128'h0000_0000_0000_0000_0000_0000_1205_0000, 8'd11},
    // R6 split reset values, R5 masking
    '{1'b0, 12'h018, 8'd8,  128'h0, 32'h0, 2'd0, 128'h0000_0000_0000_0000_1900_0000_0000_0000, 8'd6},
    '{1'b1, 12'h018, 8'd8,  128'h0000_0000_0000_0000_FFFF_FFFF_FFFF_FFFF, 32'h0, 2'd0, 128'h0, 8'd5},
    '{1'b0, 12'h018, 8'd8,  128'h0, 32'h0, 2'd0, 128'h0000_0000_0000_0000_FFF8_0000_0000_0007, 8'd5},
    // R7 R8 time pair and wrap
    '{1'b0, 12'h200, 8'd4,  128'h0, 32'h0000_1000, 2'd0, 128'h0000_0000_0000_0000_0000_0000_0000_1000, 8'd7},
    '{1'b0, 12'h204, 8'd4,  128'h0, 32'hFE00_0000, 2'd0, 128'h0000_0000_0000_0000_0000_0000_0000_007F, 8'd8},
    '{1'b0, 12'h204, 8'd4,  128'h0, 32'h0200_0000, 2'd0, 128'h0000_0000_0000_0000_0000_0000_0000_0081, 8'd7},
    '{1'b0, 12'h200, 8'd8,  128'h0, 32'h0100_0000, 2'd0, 128'h0000_0000_0000_0000_0000_0100_0100_0000, 8'd7},
    '{1'b1, 12'h204, 8'd4,  128'h0000_0000_0000_0000_0000_0000_ABCD_EFFF, 32'h0100_0000, 2'd0, 128'h0, 8'd8},
    '{1'b0, 12'h204, 8'd4,  128'h0, 32'h0100_0000, 2'd0, 128'h0000_0000_0000_0000_0000_0000_ABCD_EF80, 8'd8},
    // R10 broadcast
    '{1'b0, 12'h234, 8'd4,  128'h0, 32'h0100_0000, 2'd0, 128'h0000_0000_0000_0000_0000_0000_8000_001F, 8'd10},
    '{1'b1, 12'h234, 8'd4,  128'h0000_0000_0000_0000_0000_0000_FFFF_FFFF, 32'h0100_0000, 2'd0, 128'h0, 8'd10},
    '{1'b0, 12'h234, 8'd4,  128'h0, 32'h0100_0000, 2'd0, 128'h0000_0000_0000_0000_0000_0000_C000_001F, 8'd10},
    '{1'b1, 12'h234, 8'd4,  128'h0, 32'h0100_0000, 2'd0, 128'h0, 8'd10},
    '{1'b0, 12'h234, 8'd4,  128'h0, 32'h0100_0000, 2'd0, 128'h0000_0000_0000_0000_0000_0000_8000_001F, 8'd10},
    // R1 format errors
    '{1'b0, 12'h009, 8'd4,  128'h0, 32'h0100_0000, 2'd1, 128'h0, 8'd1},
    '{1'b0, 12'h008, 8'd6,  128'h0, 32'h0100_0000, 2'd1, 128'h0, 8'd1},
    // R4 reset-start
    '{1'b0, 12'h00C, 8'd4,  128'h0, 32'h0100_0000, 2'd1, 128'h0, 8'd4},
    '{1'b1, 12'h00C, 8'd4,  128'h0000_0000_0000_0000_0000_0000_FFFF_FFFF, 32'h0100_0000, 2'd0, 128'h0, 8'd4},
    // R3 busy-timeout hole
    '{1'b0, 12'h210, 8'd4,  128'h0, 32'h0100_0000, 2'd2, 128'h0, 8'd3},
    '{1'b1, 12'h210, 8'd4,  128'h0, 32'h0100_0000, 2'd2, 128'h0, 8'd3},
    // R12 lock-only
    '{1'b1, 12'h220, 8'd4,  128'h0, 32'h0100_0000, 2'd1, 128'h0, 8'd12},
    '{1'b0, 12'h224, 8'd4,  128'h0, 32'h0100_0000, 2'd1, 128'h0, 8'd12},
    // R3 plain hole, walk stopping at reset-start read
    '{1'b0, 12'h010, 8'd4,  128'h0, 32'h0100_0000, 2'd2, 128'h0, 8'd3},
    '{1'b0, 12'h008, 8'd12, 128'h0, 32'h0100_0000, 2'd1, 128'h0000_0000_0000_0000_0000_0000_1205_0000, 8'd3},
    // R3 partial write before a hole, then read back
    '{1'b1, 12'h01C, 8'd8,  128'h0000_0000_0000_0000_FFFF_FFFF_0010_0000, 32'h0100_0000, 2'd2, 128'h0, 8'd3},
    '{1'b0, 12'h01C, 8'd4,  128'h0, 32'h0100_0000, 2'd0, 128'h0000_0000_0000_0000_0000_0000_0010_0000, 8'd3},
    // R1 zero and oversize lengths
    '{1'b0, 12'h008, 8'd0,  128'h0, 32'h0100_0000, 2'd1, 128'h0, 8'd1},
    '{1'b0, 12'h008, 8'd20, 128'h0, 32'h0100_0000, 2'd1, 128'h0, 8'd1},
    // R3 time walk into hole at 0x208
    '{1'b0, 12'h200, 8'd16, 128'h0, 32'h0100_0000, 2'd2, 128'h0000_0000_0000_0000_ABCD_EF80_0100_0000, 8'd3}
  };

  task automatic chk(input bit ok, input int req, input string what,
                     input logic [127:0] got, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL R%0d %s got=%h exp=%h", req, what, got, exp);
    end
  endtask

  // drive at a falling edge, sample at the next falling edge (one rising edge later)
  task automatic issue(input logic w, input logic [11:0] off, input logic [7:0] len,
                       input logic [127:0] wd, input logic [31:0] cyc);
    @(negedge clk);
    req_valid   = 1'b1;
    req_write   = w;
    req_offset  = off;
    req_len     = len;
    req_wdata   = wd;
    cycle_count = cyc;
    @(negedge clk);
    req_valid   = 1'b0;
  endtask

  initial begin
    #(8 * 100000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R2 R6 R10 R11 reset state
    chk(rsp_valid == 1'b0, 2, "reset rsp_valid", 128'(rsp_valid), 128'h0);
    chk(timeout_count == 16'd800, 6, "reset timeout_count", 128'(timeout_count), 128'd800);
    chk(node_bus == 10'h3FF, 11, "reset node_bus", 128'(node_bus), 128'h3FF);
    chk(bcast_valid == 1'b0, 10, "reset bcast_valid", 128'(bcast_valid), 128'h0);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      issue(VECS[i].w, VECS[i].off, VECS[i].len, VECS[i].wd, VECS[i].cyc);
      chk(rsp_valid == 1'b1, 2, $sformatf("vec%0d rsp_valid", i), 128'(rsp_valid), 128'h1);
      chk(rsp_code == VECS[i].code, int'(VECS[i].req), $sformatf("vec%0d code", i),
          128'(rsp_code), 128'(VECS[i].code));
      chk(rsp_rdata == VECS[i].rd, int'(VECS[i].req), $sformatf("vec%0d rdata", i),
          rsp_rdata, VECS[i].rd);
    end

    // R2 response pulse ends
    @(negedge clk);
    chk(rsp_valid == 1'b0, 2, "rsp_valid drops", 128'(rsp_valid), 128'h0);
    // R6 count = 7*8192 + 2
    chk(timeout_count == 16'd57346, 6, "timeout_count", 128'(timeout_count), 128'd57346);
    // R11 bus number from earlier write
    chk(node_bus == 10'h048, 11, "node_bus", 128'(node_bus), 128'h048);
    // R10 bit cleared again
    chk(bcast_valid == 1'b0, 10, "bcast_valid", 128'(bcast_valid), 128'h0);

    // R9 cycle write pulses reload outputs
    issue(1'b1, 12'h200, 8'd4, 128'h5000_0000, 32'h0100_0000);
    chk(rsp_code == 2'd0, 9, "cycle write code", 128'(rsp_code), 128'h0);
    chk(cycle_set == 1'b1, 9, "cycle_set pulse", 128'(cycle_set), 128'h1);
    chk(cycle_set_data == 32'h5000_0000, 9, "cycle_set_data", 128'(cycle_set_data), 128'h5000_0000);
    // R9 the written value is the new previous sample: wrap on lower counter
    issue(1'b0, 12'h204, 8'd4, 128'h0, 32'h1000_0000);
    chk(cycle_set == 1'b0, 9, "cycle_set one cycle", 128'(cycle_set), 128'h0);
    chk(rsp_rdata[31:0] == 32'hABCD_F008, 9, "bus after cycle write",
        128'(rsp_rdata[31:0]), 128'hABCD_F008);

    // R10 set valid bit, check port
    issue(1'b1, 12'h234, 8'd4, 128'h4000_0000, 32'h1000_0000);
    chk(bcast_valid == 1'b1, 10, "bcast_valid set", 128'(bcast_valid), 128'h1);

    // mid-run reset restores everything
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    chk(timeout_count == 16'd800, 6, "re-reset timeout_count", 128'(timeout_count), 128'd800);
    chk(node_bus == 10'h3FF, 11, "re-reset node_bus", 128'(node_bus), 128'h3FF);
    chk(bcast_valid == 1'b0, 10, "re-reset bcast_valid", 128'(bcast_valid), 128'h0);
    rst = 1'b0;
    // R7 bus time cleared, previous sample zero: no wrap
    issue(1'b0, 12'h204, 8'd4, 128'h0, 32'h0600_0000);
    chk(rsp_rdata[31:0] == 32'h0000_0003, 7, "bus after reset",
        128'(rsp_rdata[31:0]), 128'h3);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule